// File: doc/BRIEF.md
# Capability Seal and Field-Update Unit

This execution unit takes one source capability and one authorising capability. A capability here is a tag bit, an address, an inclusive lower bound, an exclusive upper bound, a permission vector and a small object-type field. The unit applies one operation and returns the updated capability one clock later. Five operations are supported: seal, unseal, replace the address, narrow the bounds, and mask the permissions. An object type of zero marks a capability as unsealed. Any non-zero value marks it as sealed, and a sealed capability is treated as opaque.

No operation ever raises a trap. A request that is not allowed still produces a result, but that result has its tag cleared. The pipeline stage that follows only needs to inspect the tag bit to find out whether the operation was legal. Sealing stamps the low bits of the authoriser's address into the object type. Unsealing reverses this only when the authoriser's address names that same type.

Top module: `cap_seal_unit`

## Requirements
- R1: While reset is high and on the first cycle after it, `out_valid` and `out_tag` are 0.
- R2: Operation codes on `in_op` are 0 seal, 1 unseal, 2 set address, 3 set bounds and 4 mask permissions. The result appears one cycle after `in_valid` is 1, with `out_valid` set to 1. A cycle with `in_valid` at 0 gives `out_valid` 0 on the next cycle.
- R3: A seal succeeds when all of the following hold: the source is tagged and unsealed; the authoriser is tagged and unsealed; the authoriser holds the seal permission (permission bit 4); its address is non-zero, fits in the object-type width and lies inside its own bounds. A successful seal returns the tag set, the object type equal to the authoriser's address, and all other source fields unchanged.
- R4: A seal that breaks any condition in R3 returns `out_tag` 0. The broken condition may be any one of: the source is already sealed, the authoriser's address is zero, the address is too wide, the address is out of bounds, the seal permission is missing, or the authoriser is untagged.
- R5: An unseal succeeds when all of the following hold: the source is tagged and sealed; the authoriser is tagged and unsealed; the authoriser holds the unseal permission (permission bit 5); its address is inside its bounds and equals the source's object type. A successful unseal returns the tag set, object type 0, and all other fields equal to the source.
- R6: An unseal with a mismatched authoriser address, or applied to an unsealed source, returns `out_tag` 0.
- R7: Set address, set bounds or mask permissions applied to a sealed source returns `out_tag` 0.
- R8: Set address on a tagged, unsealed source returns `out_addr` equal to `opd_a`, with the tag kept.
- R9: Set bounds returns `out_base` = `opd_a` and `out_top` = `opd_b`. The tag is kept only when `src_base` <= `opd_a` <= `opd_b` <= `src_top`.
- R10: Mask permissions returns `out_perm` = `src_perm` AND `perm_mask`. The operation can clear permission bits but can never set one.
- R11: An untagged source always yields `out_tag` 0. An operation code from 5 to 7 also yields `out_tag` 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request strobe |
| in_op | input | 3 | Operation code |
| src_tag | input | 1 | Source tag |
| src_addr | input | ADDR_W | Source address |
| src_base | input | ADDR_W | Source lower bound |
| src_top | input | ADDR_W | Source exclusive upper bound |
| src_perm | input | PERM_W | Source permissions |
| src_otype | input | OTYPE_W | Source object type |
| auth_tag | input | 1 | Authoriser tag |
| auth_addr | input | ADDR_W | Authoriser address |
| auth_base | input | ADDR_W | Authoriser lower bound |
| auth_top | input | ADDR_W | Authoriser exclusive upper bound |
| auth_perm | input | PERM_W | Authoriser permissions |
| auth_otype | input | OTYPE_W | Authoriser object type |
| opd_a | input | ADDR_W | New address, or new lower bound |
| opd_b | input | ADDR_W | New upper bound |
| perm_mask | input | PERM_W | Permission mask |
| out_valid | output | 1 | Result strobe |
| out_tag | output | 1 | Result tag |
| out_addr | output | ADDR_W | Result address |
| out_base | output | ADDR_W | Result lower bound |
| out_top | output | ADDR_W | Result upper bound |
| out_perm | output | PERM_W | Result permissions |
| out_otype | output | OTYPE_W | Result object type |

## Verification
The unit holds no state beyond its one output register. A wrong decision therefore shows up at the ports exactly one cycle after the request, and it shows up as a wrong tag or a wrong field value. A fault in the authorisation check is the dangerous kind, because it leaves a forged capability with its tag still set. For that reason every rule that would reject a request is tested on its own, with all the other conditions held legal. This way a check that has been lost or inverted surfaces as a set tag on the very next result.

// File: rtl/capu_pkg.sv
`timescale 1ns/1ps
package capu_pkg;
  typedef enum logic [2:0] {
    OP_SEAL    = 3'd0,
    OP_UNSEAL  = 3'd1,
    OP_SETADDR = 3'd2,
    OP_SETBND  = 3'd3,
    OP_ANDPERM = 3'd4
  } capu_op_e;

  localparam int PB_SEAL   = 4;
  localparam int PB_UNSEAL = 5;
endpackage

// File: rtl/capu_auth_chk.sv
`timescale 1ns/1ps
module capu_auth_chk #(
  parameter int ADDR_W  = 32,
  parameter int OTYPE_W = 3
) (
  input  logic               auth_tag,
  input  logic [ADDR_W-1:0]  auth_addr,
  input  logic [ADDR_W-1:0]  auth_base,
  input  logic [ADDR_W-1:0]  auth_top,
  input  logic               auth_may_seal,
  input  logic               auth_may_unseal,
  input  logic [OTYPE_W-1:0] auth_otype,
  input  logic [OTYPE_W-1:0] src_otype,
  output logic               seal_ok,
  output logic               unseal_ok
);
  localparam int PAD_W = ADDR_W - OTYPE_W;

  logic addr_in_bounds;
  logic addr_fits;
  logic auth_usable;
  logic src_sealed;
  logic [ADDR_W-1:0] src_type_wide;

  always_comb begin
    addr_in_bounds = (auth_addr >= auth_base) && (auth_addr < auth_top);
    addr_fits      = (auth_addr[ADDR_W-1:OTYPE_W] == {PAD_W{1'b0}});
    auth_usable    = auth_tag && (auth_otype == '0) && addr_in_bounds;
    src_sealed     = (src_otype != '0);
    src_type_wide  = {{PAD_W{1'b0}}, src_otype};

    seal_ok   = auth_usable && auth_may_seal && addr_fits &&
                (auth_addr != '0) && !src_sealed;
    unseal_ok = auth_usable && auth_may_unseal && src_sealed &&
                (auth_addr == src_type_wide);
  end
endmodule

// File: rtl/capu_field_mod.sv
`timescale 1ns/1ps
module capu_field_mod #(
  parameter int ADDR_W = 32,
  parameter int PERM_W = 8
) (
  input  logic [ADDR_W-1:0] src_base,
  input  logic [ADDR_W-1:0] src_top,
  input  logic [PERM_W-1:0] src_perm,
  input  logic [ADDR_W-1:0] new_lo,
  input  logic [ADDR_W-1:0] new_hi,
  input  logic [PERM_W-1:0] mask,
  output logic              bounds_ok,
  output logic [PERM_W-1:0] perm_new
);
  always_comb begin
    bounds_ok = (src_base <= new_lo) && (new_lo <= new_hi) && (new_hi <= src_top);
    perm_new  = src_perm & mask;
  end
endmodule

// File: rtl/cap_seal_unit.sv
`timescale 1ns/1ps
module cap_seal_unit #(
  parameter int ADDR_W  = 32,
  parameter int PERM_W  = 8,
  parameter int OTYPE_W = 3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               in_valid,
  input  logic [2:0]         in_op,
  input  logic               src_tag,
  input  logic [ADDR_W-1:0]  src_addr,
  input  logic [ADDR_W-1:0]  src_base,
  input  logic [ADDR_W-1:0]  src_top,
  input  logic [PERM_W-1:0]  src_perm,
  input  logic [OTYPE_W-1:0] src_otype,
  input  logic               auth_tag,
  input  logic [ADDR_W-1:0]  auth_addr,
  input  logic [ADDR_W-1:0]  auth_base,
  input  logic [ADDR_W-1:0]  auth_top,
  input  logic [PERM_W-1:0]  auth_perm,
  input  logic [OTYPE_W-1:0] auth_otype,
  input  logic [ADDR_W-1:0]  opd_a,
  input  logic [ADDR_W-1:0]  opd_b,
  input  logic [PERM_W-1:0]  perm_mask,
  output logic               out_valid,
  output logic               out_tag,
  output logic [ADDR_W-1:0]  out_addr,
  output logic [ADDR_W-1:0]  out_base,
  output logic [ADDR_W-1:0]  out_top,
  output logic [PERM_W-1:0]  out_perm,
  output logic [OTYPE_W-1:0] out_otype
);
  import capu_pkg::*;

  logic seal_ok, unseal_ok, bounds_ok;
  logic [PERM_W-1:0] masked_perm;
  logic unused_perm_bits;
  assign unused_perm_bits = ^auth_perm;

  capu_auth_chk #(.ADDR_W(ADDR_W), .OTYPE_W(OTYPE_W)) u_auth (
    .auth_tag       (auth_tag),
    .auth_addr      (auth_addr),
    .auth_base      (auth_base),
    .auth_top       (auth_top),
    .auth_may_seal  (auth_perm[PB_SEAL]),
    .auth_may_unseal(auth_perm[PB_UNSEAL]),
    .auth_otype     (auth_otype),
    .src_otype      (src_otype),
    .seal_ok        (seal_ok),
    .unseal_ok      (unseal_ok)
  );

  capu_field_mod #(.ADDR_W(ADDR_W), .PERM_W(PERM_W)) u_mod (
    .src_base (src_base),
    .src_top  (src_top),
    .src_perm (src_perm),
    .new_lo   (opd_a),
    .new_hi   (opd_b),
    .mask     (perm_mask),
    .bounds_ok(bounds_ok),
    .perm_new (masked_perm)
  );

  logic               nx_tag;
  logic [ADDR_W-1:0]  nx_addr, nx_base, nx_top;
  logic [PERM_W-1:0]  nx_perm;
  logic [OTYPE_W-1:0] nx_otype;
  logic               src_sealed;

  always_comb begin
    src_sealed = (src_otype != '0);
    nx_tag   = 1'b0;
    nx_addr  = src_addr;
    nx_base  = src_base;
    nx_top   = src_top;
    nx_perm  = src_perm;
    nx_otype = src_otype;
    case (in_op)
      OP_SEAL: begin
        nx_tag   = src_tag && seal_ok;
        nx_otype = auth_addr[OTYPE_W-1:0];
      end
      OP_UNSEAL: begin
        nx_tag   = src_tag && unseal_ok;
        nx_otype = '0;
      end
      OP_SETADDR: begin
        nx_tag  = src_tag && !src_sealed;
        nx_addr = opd_a;
      end
      OP_SETBND: begin
        nx_tag  = src_tag && !src_sealed && bounds_ok;
        nx_base = opd_a;
        nx_top  = opd_b;
      end
      OP_ANDPERM: begin
        nx_tag  = src_tag && !src_sealed;
        nx_perm = masked_perm;
      end
      default: nx_tag = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_tag   <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_tag   <= nx_tag;
        out_addr  <= nx_addr;
        out_base  <= nx_base;
        out_top   <= nx_top;
        out_perm  <= nx_perm;
        out_otype <= nx_otype;
      end
    end
  end

  // R2: one-cycle strobe
  a_r2_valid_follows: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  a_r2_idle_follows: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);
  // R11: an untagged source never yields a tagged result
  a_r11_untagged_src: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !src_tag) |=> !out_tag);
  // R7: a sealed source cannot be modified
  a_r7_sealed_opaque: assert property (@(posedge clk) disable iff (rst)
    (in_valid && src_otype != '0 &&
     (in_op == OP_SETADDR || in_op == OP_SETBND || in_op == OP_ANDPERM)) |=> !out_tag);
  // R10: masking permissions never adds a bit
  a_r10_perm_subset: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_op == OP_ANDPERM) |=> ((out_perm & ~$past(src_perm)) == '0));
  // R3: a tagged seal result carries the authoriser's address as its type
  a_r3_seal_type: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_op == OP_SEAL) |=>
      (!out_tag || (out_otype != '0 && out_otype == $past(auth_addr[OTYPE_W-1:0]))));
  // R5: a tagged unseal result is unsealed
  a_r5_unseal_clear: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_op == OP_UNSEAL) |=> (!out_tag || out_otype == '0));
endmodule

// File: tb/sim_cap_seal_unit.sv
`timescale 1ns/1ps
module sim_cap_seal_unit;
  localparam int AW = 32;
  localparam int PW = 8;
  localparam int TW = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic [2:0] in_op = '0;
  logic src_tag = 1'b0, auth_tag = 1'b0;
  logic [AW-1:0] src_addr = '0, src_base = '0, src_top = '0;
  logic [AW-1:0] auth_addr = '0, auth_base = '0, auth_top = '0;
  logic [AW-1:0] opd_a = '0, opd_b = '0;
  logic [PW-1:0] src_perm = '0, auth_perm = '0, perm_mask = '0;
  logic [TW-1:0] src_otype = '0, auth_otype = '0;
  logic out_valid, out_tag;
  logic [AW-1:0] out_addr, out_base, out_top;
  logic [PW-1:0] out_perm;
  logic [TW-1:0] out_otype;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  cap_seal_unit #(.ADDR_W(AW), .PERM_W(PW), .OTYPE_W(TW)) u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_op(in_op),
    .src_tag(src_tag), .src_addr(src_addr), .src_base(src_base), .src_top(src_top),
    .src_perm(src_perm), .src_otype(src_otype),
    .auth_tag(auth_tag), .auth_addr(auth_addr), .auth_base(auth_base), .auth_top(auth_top),
    .auth_perm(auth_perm), .auth_otype(auth_otype),
    .opd_a(opd_a), .opd_b(opd_b), .perm_mask(perm_mask),
    .out_valid(out_valid), .out_tag(out_tag), .out_addr(out_addr), .out_base(out_base),
    .out_top(out_top), .out_perm(out_perm), .out_otype(out_otype)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // legal baseline: tagged unsealed source, tagged authoriser able to seal and unseal type 3
  task automatic setup();
    src_tag = 1'b1; src_addr = 32'h1040; src_base = 32'h1000; src_top = 32'h1100;
    src_perm = 8'h0F; src_otype = '0;
    auth_tag = 1'b1; auth_addr = 32'd3; auth_base = 32'd0; auth_top = 32'd8;
    auth_perm = 8'h30; auth_otype = '0;
    opd_a = '0; opd_b = '0; perm_mask = '0;
  endtask

  task automatic fire(input logic [2:0] op);
    @(negedge clk);
    in_op = op; in_valid = 1'b1;
    @(posedge clk); #1;
    in_valid = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 valid", {63'd0, out_valid}, 64'd0);
    chk("R1 tag", {63'd0, out_tag}, 64'd0);
  endtask

  task automatic t_seal_ok();
    setup(); fire(3'd0);
    chk("R2 valid", {63'd0, out_valid}, 64'd1);
    chk("R3 tag", {63'd0, out_tag}, 64'd1);
    chk("R3 otype", {61'd0, out_otype}, 64'd3);
    chk("R3 addr", {32'd0, out_addr}, 64'h1040);
    chk("R3 perm", {56'd0, out_perm}, 64'h0F);
    @(posedge clk); #1;
    chk("R2 idle", {63'd0, out_valid}, 64'd0);
  endtask

  task automatic t_seal_bad();
    setup(); src_otype = 3'd2; fire(3'd0);
    chk("R4 already sealed", {63'd0, out_tag}, 64'd0);
    setup(); auth_addr = 32'd0; fire(3'd0);
    chk("R4 zero type", {63'd0, out_tag}, 64'd0);
    setup(); auth_addr = 32'd9; auth_top = 32'd16; fire(3'd0);
    chk("R4 too wide", {63'd0, out_tag}, 64'd0);
    setup(); auth_addr = 32'd5; auth_top = 32'd4; fire(3'd0);
    chk("R4 out of bounds", {63'd0, out_tag}, 64'd0);
    setup(); auth_perm = 8'h20; fire(3'd0);
    chk("R4 no seal perm", {63'd0, out_tag}, 64'd0);
    setup(); auth_tag = 1'b0; fire(3'd0);
    chk("R4 untagged auth", {63'd0, out_tag}, 64'd0);
  endtask

  task automatic t_unseal();
    setup(); src_otype = 3'd3; fire(3'd1);
    chk("R5 tag", {63'd0, out_tag}, 64'd1);
    chk("R5 otype", {61'd0, out_otype}, 64'd0);
    chk("R5 top", {32'd0, out_top}, 64'h1100);
    setup(); src_otype = 3'd3; auth_perm = 8'h10; fire(3'd1);
    chk("R5 no unseal perm", {63'd0, out_tag}, 64'd0);
    setup(); src_otype = 3'd3; auth_addr = 32'd2; fire(3'd1);
    chk("R6 mismatch", {63'd0, out_tag}, 64'd0);
    setup(); auth_addr = 32'd0; fire(3'd1);
    chk("R6 unsealed input", {63'd0, out_tag}, 64'd0);
  endtask

  task automatic t_sealed_mods();
    setup(); src_otype = 3'd2; opd_a = 32'h1050; fire(3'd2);
    chk("R7 set address", {63'd0, out_tag}, 64'd0);
    setup(); src_otype = 3'd2; opd_a = 32'h1000; opd_b = 32'h1080; fire(3'd3);
    chk("R7 set bounds", {63'd0, out_tag}, 64'd0);
    setup(); src_otype = 3'd2; perm_mask = 8'hFF; fire(3'd4);
    chk("R7 mask perm", {63'd0, out_tag}, 64'd0);
  endtask

  task automatic t_modify();
    setup(); opd_a = 32'h10F0; fire(3'd2);
    chk("R8 tag", {63'd0, out_tag}, 64'd1);
    chk("R8 addr", {32'd0, out_addr}, 64'h10F0);
    setup(); opd_a = 32'h1010; opd_b = 32'h1080; fire(3'd3);
    chk("R9 tag", {63'd0, out_tag}, 64'd1);
    chk("R9 base", {32'd0, out_base}, 64'h1010);
    chk("R9 top", {32'd0, out_top}, 64'h1080);
    setup(); opd_a = 32'h1000; opd_b = 32'h1200; fire(3'd3);
    chk("R9 widen", {63'd0, out_tag}, 64'd0);
    setup(); opd_a = 32'h1080; opd_b = 32'h1010; fire(3'd3);
    chk("R9 inverted", {63'd0, out_tag}, 64'd0);
    setup(); perm_mask = 8'hF3; fire(3'd4);
    chk("R10 tag", {63'd0, out_tag}, 64'd1);
    chk("R10 perm", {56'd0, out_perm}, 64'h03);
  endtask

  task automatic t_untagged();
    setup(); src_tag = 1'b0; opd_a = 32'h1010; fire(3'd2);
    chk("R11 untagged source", {63'd0, out_tag}, 64'd0);
    setup(); fire(3'd6);
    chk("R11 bad opcode", {63'd0, out_tag}, 64'd0);
    chk("R2 valid bad op", {63'd0, out_valid}, 64'd1);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1; t_reset();
    @(negedge clk); rst = 1'b0;
    @(posedge clk); #1;
    t_reset();
    t_seal_ok();
    t_seal_bad();
    t_unseal();
    t_sealed_mods();
    t_modify();
    t_untagged();
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    #100000;
    if (!finished) begin
      finished = 1'b1;
      checks++; failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule